// File: doc/BRIEF.md
# Packet-Aware Receive Byte Buffer

This block stores bytes that arrive from a USB OUT endpoint until the CPU reads them. The storage is 32 bytes deep and first-in, first-out. The packet engine pushes bytes with a valid/ready pair. Before it starts an OUT packet, it samples `pkt_accept_ok`. That output is high only while the free space covers one whole maximum-size packet (32 bytes). Backpressure is therefore applied per packet and not per byte: the engine refuses a packet it could not store completely, rather than cutting it short. Once a packet has been accepted, all of its bytes are known to fit.

On the CPU side, a one-cycle read strobe pops the oldest byte. The byte appears on the read-data port on the following cycle. The block also reports:
- the fill level;
- a one-cycle watermark pulse, when the level climbs to a threshold chosen by a 3-bit code;
- a one-cycle overflow pulse, when a byte is offered while the storage is full.

A synchronous active-high reset discards the contents and clears all pending events.

Top module: `rx_pkt_buffer`

## Requirements
- R1: Bytes leave through `rd_data` in the same order as they were accepted on `in_data`.
- R2: `in_ready` is high exactly when `level` is below 32. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- R3: A byte offered (`in_valid` high) while `level` is 32 is discarded, and `level` does not rise. Fullness is judged before any pop in the same cycle. `irq_overflow` is high for exactly the one cycle after each such edge.
- R4: When `rd_pop` is high at an edge and the buffer holds data, `rd_data` shows the oldest byte from the next cycle onward and holds it until the next pop.
- R5: A pop while `level` is 0 makes `rd_data` read 0xFF from the next cycle, and leaves `level` unchanged. A push in that same cycle is still stored.
- R6: `level` is a 6-bit count from 0 to 32. It updates one cycle after each edge, and it stays unchanged when a push and a pop both succeed at the same edge.
- R7: `pkt_accept_ok` is high exactly when the free space (32 − `level`) is at least 32 bytes, which means only while the buffer is empty.
- R8: The watermark code `wm_sel` selects the threshold: 0 → 1, 1 → 4, 2 → 8, 3 → 16, and 4 to 7 → 30. `irq_watermark` is high for one cycle whenever `level` moves from below the threshold to at or above it.
- R9: After synchronous reset, `level` is 0, `rd_data` is 0xFF, `pkt_accept_ok` is 1, both pulses are 0, and earlier contents are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet side offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Room for at least one byte |
| pkt_accept_ok | output | 1 | Room for a whole maximum-size packet |
| rd_pop | input | 1 | CPU read strobe, pops one byte |
| rd_data | output | 8 | Oldest byte after a pop, 0xFF after a pop on empty |
| level | output | 6 | Current fill level, 0 to 32 |
| wm_sel | input | 3 | Watermark threshold code |
| irq_watermark | output | 1 | One-cycle pulse when the level reaches the threshold |
| irq_overflow | output | 1 | One-cycle pulse after a byte is dropped because the buffer is full |

## Verification
The embedded properties check the following on every cycle:
- the level never goes past 32;
- a pop on empty with no push leaves the level at zero and yields 0xFF;
- an offer while full keeps the buffer full and is followed by an overflow pulse;
- the packet-accept flag never claims room that is not there;
- a watermark pulse always comes with a level at or above the threshold.

Only the bench's scenarios can show the following:
- byte ordering across pointer wrap;
- the exact threshold for each of the eight codes;
- the overflow judged before a same-cycle pop;
- the mid-stream reset.

The cycle-level model covers these by comparing every output on every cycle during directed and random traffic.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // Threshold selected by the 3-bit watermark code; codes 4..7 share top level
  function automatic int unsigned wm_threshold(input logic [2:0] code,
                                               input int unsigned top_lvl);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      default: return top_lvl;
    endcase
  endfunction

endpackage

// File: rtl/rxb_mem.sv
module rxb_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdq
);

  // Simple dual-port array with registered read for block RAM inference
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdq <= mem[raddr];
  end

endmodule

// File: rtl/rxb_ptr_ctrl.sv
module rxb_ptr_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] cnt,
  output logic [LW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (cnt == FULL_LVL);
  assign empty   = (cnt == '0);
  // Fullness judged on the current count, before any pop of this cycle
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;

  always_comb begin
    case ({push_ok, pop_ok})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_LVL);

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push_req) |=> (cnt == '0));

  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && full && !pop_req) |=> full);

endmodule

// File: rtl/rxb_events.sv
module rxb_events #(
  parameter int DEPTH   = 32,
  parameter int PKT_MAX = 32,
  parameter int WM_TOP  = 30,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] cnt,
  input  logic [LW-1:0] cnt_nxt,
  input  logic [2:0]    wm_sel,
  input  logic          ovf_evt,
  output logic          irq_wm,
  output logic          irq_ovf,
  output logic          accept
);

  // Largest level at which one full packet still fits
  localparam logic [LW-1:0] ACC_MAX = LW'(DEPTH - PKT_MAX);

  logic [LW-1:0] thr;
  assign thr = LW'(rxb_pkg::wm_threshold(wm_sel, WM_TOP));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_wm  <= 1'b0;
      irq_ovf <= 1'b0;
      accept  <= 1'b1;
    end else begin
      irq_wm  <= (cnt_nxt >= thr) && (cnt < thr);
      irq_ovf <= ovf_evt;
      accept  <= (cnt_nxt <= ACC_MAX);
    end
  end

  // R7
  accept_room_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (cnt <= ACC_MAX));

  // R3
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> irq_ovf);

  // R8
  wm_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wm |-> (cnt >= $past(thr)));

endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer #(
  parameter int DW      = 8,
  parameter int DEPTH   = 32,
  parameter int PKT_MAX = 32,
  parameter int WM_TOP  = 30,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          pkt_accept_ok,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  input  logic [2:0]    wm_sel,
  output logic          irq_watermark,
  output logic          irq_overflow
);

  logic          push_ok, pop_ok, full, empty;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [LW-1:0] cnt, cnt_nxt;
  logic [DW-1:0] rdq;
  logic          rd_blank;

  rxb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .push_req(in_valid),
    .pop_req (rd_pop),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .full    (full),
    .empty   (empty)
  );

  rxb_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (push_ok),
    .waddr(wr_addr),
    .wdata(in_data),
    .re   (pop_ok),
    .raddr(rd_addr),
    .rdq  (rdq)
  );

  rxb_events #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX), .WM_TOP(WM_TOP)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt),
    .cnt_nxt(cnt_nxt),
    .wm_sel (wm_sel),
    .ovf_evt(in_valid && full),
    .irq_wm (irq_watermark),
    .irq_ovf(irq_overflow),
    .accept (pkt_accept_ok)
  );

  // Marks that the last pop found nothing; masks the RAM output register
  always_ff @(posedge clk) begin
    if (rst)         rd_blank <= 1'b1;
    else if (rd_pop) rd_blank <= empty;
  end

  assign rd_data  = rd_blank ? '1 : rdq;
  assign level    = cnt;
  assign in_ready = !full;

  // R2
  accepted_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (level != '0));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && level == '0) |=> (rd_data == '1));

endmodule

// File: tb/rx_pkt_buffer_test.sv
module rx_pkt_buffer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       rd_pop = 1'b0;
  logic [2:0] wm_sel = 3'd0;
  logic       in_ready, pkt_accept_ok, irq_watermark, irq_overflow;
  logic [7:0] rd_data;
  logic [5:0] level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_pkt_buffer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_accept_ok(pkt_accept_ok), .rd_pop(rd_pop),
    .rd_data(rd_data), .level(level), .wm_sel(wm_sel),
    .irq_watermark(irq_watermark), .irq_overflow(irq_overflow)
  );

  // Behavioural reference model
  byte unsigned q[$];
  int e_rd = 255, e_acc = 1, e_wm = 0, e_ovf = 0;

  function automatic int ref_thr(input int code);
    if (code >= 4) return 30;
    if (code == 0) return 1;
    return 2 << code;
  endfunction

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      q.delete();
      e_rd = 255; e_acc = 1; e_wm = 0; e_ovf = 0;
    end else begin
      int pre;
      int post;
      int t;
      pre = q.size();
      e_ovf = (in_valid && pre == 32) ? 1 : 0;
      if (rd_pop) begin
        if (pre > 0) e_rd = q.pop_front();
        else e_rd = 255;
      end
      if (in_valid && pre < 32) q.push_back(in_data);
      post = q.size();
      t = ref_thr(int'(wm_sel));
      e_wm = (post >= t && pre < t) ? 1 : 0;
      e_acc = ((32 - post) >= 32) ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R6 level", int'(level), q.size());
      chk("R2 in_ready", int'(in_ready), (q.size() < 32) ? 1 : 0);
      chk("R1 R4 R5 rd_data", int'(rd_data), e_rd);
      chk("R7 pkt_accept_ok", int'(pkt_accept_ok), e_acc);
      chk("R8 irq_watermark", int'(irq_watermark), e_wm);
      chk("R3 irq_overflow", int'(irq_overflow), e_ovf);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic v, input logic [7:0] d, input logic p);
    in_valid = v; in_data = d; rd_pop = p;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 8'h00, 0);
    step(0, 8'h00, 0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(0, 8'h00, 0);            // R9 reset state compared here
    // R5: pops on empty
    step(0, 8'h00, 1);
    step(0, 8'h00, 1);
    // R7, R8: one full packet with watermark 8
    wm_sel = 3'd2;
    for (int i = 0; i < 32; i++) step(1, 8'(i * 7 + 3), 0);
    // R3: offers while full, then one with a same-cycle pop
    step(1, 8'hAA, 0);
    step(1, 8'hBB, 0);
    step(1, 8'hCC, 1);
    step(0, 8'h00, 0);
    // R1 R4: drain in order, then extra pops
    for (int i = 0; i < 34; i++) step(0, 8'h00, 1);
    // R5: push with pop on empty
    step(1, 8'h5A, 1);
    step(0, 8'h00, 1);
    // R6: concurrent push and pop at mid level
    for (int i = 0; i < 5; i++) step(1, 8'(8'h40 + i), 0);
    for (int i = 0; i < 12; i++) step(1, 8'(8'h80 + i), 1);
    for (int i = 0; i < 6; i++) step(0, 8'h00, 1);
    // R8: every watermark code
    for (int c = 0; c < 8; c++) begin
      wm_sel = 3'(c);
      for (int i = 0; i < 31; i++) step(1, 8'(c * 16 + i), 0);
      for (int i = 0; i < 31; i++) step(0, 8'h00, 1);
    end
    // R9: reset with data inside
    for (int i = 0; i < 10; i++) step(1, 8'(8'hE0 + i), 0);
    do_reset();
    step(0, 8'h00, 1);
    step(0, 8'h00, 0);
    // Mixed traffic wrapping the pointers
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) wm_sel = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 99) < 55), 8'($urandom_range(0, 255)),
           ($urandom_range(0, 99) < 45));
    end
    step(0, 8'h00, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule